// File: doc/BRIEF.md
# Palette Loader and Colour Lookup

This block sits between a frame DMA and the panel data path of a display controller. It takes a stream of 16-bit words under a valid/ready handshake. While a palette is being loaded, the words fill a colour lookup table of up to 256 entries. The first word of a palette also carries a pixel-depth code, and that code sets how the frame data that follows is cut into pixels.

While frame data is flowing, each word is split into pixels, least significant bits first. At 1, 2, 4 and 8 bits per pixel, each pixel indexes the table. For 12/16-bit formats the word passes straight through. The result leaves as a 12-bit RGB pixel under its own valid/ready handshake.

A run is started by raising `run`. The two-bit `load_mode` is sampled at that moment and picks one of three sequences: palette then frame, palette only (which stops after the palette), or frame only. A one-cycle `pal_done` pulse tells the control unit that the palette is in place.

Top module: `clut_unpacker`

## Requirements
- R1: After reset `in_ready`, `pix_valid` and `pal_done` are low. Every table entry is zero and the depth is 8 bits per pixel.
- R2: `load_mode` is sampled in the first cycle of a run. 2'b00 selects palette then frame, 2'b01 palette only, and 2'b10 or 2'b11 frame only. While `run` is low, `in_ready` and `pix_valid` are low in that same cycle and the block returns to idle. No pixel appears before a run has started.
- R3: Bits 15:12 of the first palette word set the depth: 0 for 1 bpp, 1 for 2 bpp, 2 for 4 bpp, 3 for 8 bpp, and 4 to 15 for 12/16-bit pass-through. Bits 15:12 of every later palette word are ignored.
- R4: Palette word i is stored in table entry i as its low 12 bits: red in 11:8, green in 7:4, blue in 3:0.
- R5: A palette is 258 words at depth code 3 (256 stored), 130 words at codes 0 to 2 (128 stored), and 18 words at codes 4 to 15 (16 stored). The last two words of each palette are accepted and discarded.
- R6: `pal_done` is high for exactly one cycle, the cycle after the last palette word is accepted.
- R7: In palette-only mode, once the palette is complete `in_ready` and `pix_valid` stay low until `run` is dropped.
- R8: In palette-then-frame mode, the words that follow the palette in the same run are frame data. No pixel is produced while the palette is loading.
- R9: At b = 1, 2, 4 or 8 bits per pixel, each frame word yields 16/b pixels. Pixel j is the table entry indexed by word bits [j*b+b-1 : j*b], so the least significant field comes out first.
- R10: In pass-through depth, each frame word yields one pixel equal to its bits 11:0.
- R11: Frame data sent before any palette load is looked up at 8 bpp in the zero-cleared table, so every pixel is zero.
- R12: While `pix_ready` is low, `pix_valid` and `pix_data` hold steady and no pixel is lost or reordered. The table and depth persist from one run to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Run enable; a rising level starts a sequence |
| load_mode | input | 2 | Sequence select, sampled at run start |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 16 | Palette or frame word |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Output pixel taken when high with `pix_valid` |
| pix_data | output | 12 | RGB pixel, 4 bits per channel |
| pal_done | output | 1 | One-cycle pulse when a palette load ends |

## Verification
Frame data is sent at every depth code: 0, 1, 2, 3, the pass-through code 4, and an out-of-range code 9. Each depth produces a different number of pixels per word and a different index field. A wrong field width, a wrong field order or a wrong palette length therefore shifts or reorders the whole pixel sequence.

Palette words carry a nonzero upper nibble after word 0, which shows whether only the first word sets the depth. Each palette ends in two surplus words that must not become table entries or pixels. Frame data sent before any palette separates a zero-cleared table from any other initial state. A run with a stalling pixel consumer, and a frame-only run after that, separate correct holding and table retention from lost, repeated or reset pixels.

// File: rtl/clut_unpacker.sv
module clut_unpacker #(
  parameter int WORD_W      = 16,
  parameter int COLOR_W     = 12,
  parameter int ENTRIES     = 256,
  parameter int HDR_ENTRIES = 16,
  parameter int SURPLUS     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [1:0]         load_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [COLOR_W-1:0] pix_data,
  output logic               pal_done
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(ENTRIES + SURPLUS + 1);
  localparam int LEFT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(ENTRIES + SURPLUS - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(ENTRIES / 2 + SURPLUS - 1);
  localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_ENTRIES + SURPLUS - 1);

  typedef enum logic [1:0] {S_IDLE, S_PAL, S_FRM, S_HALT} state_t;

  state_t              state;
  logic                pal_only;
  logic [3:0]          code;
  logic [CNT_W-1:0]    wcnt, last_cnt;
  logic [COLOR_W-1:0]  lut [ENTRIES];
  logic [WORD_W-1:0]   sh;
  logic [LEFT_W-1:0]   left;
  logic                done_q;

  logic                passthru;
  logic [1:0]          lg;
  logic [5:0]          bpp;
  logic [LEFT_W-1:0]   ppw;
  logic [IDX_W-1:0]    idx_mask, idx;
  logic                acc, wr_en, last_word;

  function automatic logic [CNT_W-1:0] last_for(input logic [3:0] c);
    if (c == 4'd3)     return LAST_FULL;
    else if (c < 4'd3) return LAST_HALF;
    else               return LAST_HDR;
  endfunction

  assign passthru = code > 4'd3;
  assign lg       = code[1:0];
  assign bpp      = passthru ? 6'(WORD_W) : 6'(1 << lg);
  assign ppw      = passthru ? LEFT_W'(1) : LEFT_W'(WORD_W >> lg);
  assign idx_mask = passthru ? '1 : IDX_W'((32'd1 << bpp) - 32'd1);
  assign idx      = sh[IDX_W-1:0] & idx_mask;

  assign pix_valid = run && (state == S_FRM) && (left != '0);
  assign pix_data  = passthru ? sh[COLOR_W-1:0] : lut[idx];
  assign in_ready  = run && ((state == S_PAL) ||
                     ((state == S_FRM) && ((left == '0) || ((left == LEFT_W'(1)) && pix_ready))));
  assign acc       = in_valid && in_ready;
  assign last_word = (wcnt != '0) && (wcnt == last_cnt);
  assign wr_en     = acc && (state == S_PAL) &&
                     ((wcnt == '0) || ({1'b0, wcnt} + (CNT_W+1)'(SURPLUS) <= {1'b0, last_cnt}));
  assign pal_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pal_only <= 1'b0;
      code     <= 4'd3;
      wcnt     <= '0;
      last_cnt <= LAST_FULL;
      sh       <= '0;
      left     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        state <= S_IDLE;
        wcnt  <= '0;
        left  <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            pal_only <= (load_mode == 2'b01);
            state    <= load_mode[1] ? S_FRM : S_PAL;
          end
          S_PAL: if (in_valid) begin
            if (wcnt == '0) begin
              code     <= in_data[WORD_W-1 -: 4];
              last_cnt <= last_for(in_data[WORD_W-1 -: 4]);
            end
            if (last_word) begin
              wcnt   <= '0;
              done_q <= 1'b1;
              state  <= pal_only ? S_HALT : S_FRM;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_FRM: begin
            if (acc) begin
              sh   <= in_data;
              left <= ppw;
            end else if (pix_valid && pix_ready) begin
              sh   <= sh >> bpp;
              left <= left - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) lut[i] <= '0;
    end else if (wr_en) begin
      lut[wcnt[IDX_W-1:0]] <= in_data[COLOR_W-1:0];
    end
  end
endmodule

module clut_unpacker_chk #(
  parameter int COLOR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [1:0]         load_mode,
  input logic               in_ready,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic [COLOR_W-1:0] pix_data,
  input logic               pal_done
);
  logic run_q, po;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      po    <= 1'b0;
    end else begin
      run_q <= run;
      if (run && !run_q) po <= (load_mode == 2'b01);
    end
  end

  AST_NO_PIX_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(run)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |=> !pal_done); // R6
  AST_PALONLY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_done && po) |-> (!in_ready && !pix_valid)); // R7
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && run) |=> (!run || (pix_valid && $stable(pix_data)))); // R12
endmodule

bind clut_unpacker clut_unpacker_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .load_mode(load_mode), .in_ready(in_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pal_done(pal_done)
);

// File: tb/clut_unpacker_bench.sv
`timescale 1ns/1ps
module clut_unpacker_bench;
  logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, in_valid = 1'b0, pix_ready = 1'b1;
  logic [1:0]  load_mode = 2'b00;
  logic [15:0] in_data = '0;
  logic        in_ready, pix_valid, pal_done;
  logic [11:0] pix_data;

  always #2 clk = ~clk;

  clut_unpacker u_clut_unpacker (
    .clk(clk), .rst_n(rst_n), .run(run), .load_mode(load_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pal_done(pal_done)
  );

  int n_chk = 0, n_bad = 0, done_cnt = 0, cyc = 0;
  bit bp_en = 1'b0, finished = 1'b0;
  logic [11:0] exp_tab [256];
  logic [3:0]  cur_code = 4'd3;
  logic [11:0] got_q[$], exp_q[$];

  always @(negedge clk) begin
    cyc++;
    pix_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (pix_valid === 1'b1 && pix_ready) got_q.push_back(pix_data);
    if (pal_done === 1'b1) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] col(input int i, input int seed);
    return 12'(i * 37 + seed * 101 + 5);
  endfunction

  function automatic int bpp_of(input logic [3:0] c);
    return (c > 4'd3) ? 16 : (1 << c[1:0]);
  endfunction

  function automatic int entries_of(input logic [3:0] c);
    return (c == 4'd3) ? 256 : (c < 4'd3) ? 128 : 16;
  endfunction

  task automatic send(input logic [15:0] w);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    ok = 1'b0;
    while (!ok) begin
      #1 ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end
  endtask

  task automatic start(input logic [1:0] mode);
    @(negedge clk);
    load_mode = mode;
    run = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk);
    run = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R2", "in_ready with run low", int'(in_ready), 0);
    chk(pix_valid == 1'b0, "R2", "pix_valid with run low", int'(pix_valid), 0);
  endtask

  task automatic load_pal(input logic [3:0] c, input int seed, input bit halt_mode);
    int n, d0;
    n  = entries_of(c);
    d0 = done_cnt;
    got_q.delete();
    for (int i = 0; i < n + 2; i++) begin
      logic [15:0] w;
      if (i == 0)    w = {c, col(0, seed)};
      else if (i < n) w = {4'hA, col(i, seed)};
      else           w = 16'hBEEF;
      if (i < n) exp_tab[i] = col(i, seed);
      send(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(pal_done === 1'b1, "R6", "pal_done after last word", int'(pal_done), 1);
    repeat (4) @(negedge clk);
    #2;
    chk(done_cnt - d0 == 1, "R6", "pal_done pulse count", done_cnt - d0, 1);
    chk(got_q.size() == 0, "R8", "pixels during palette", got_q.size(), 0);
    cur_code = c;
    if (halt_mode) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'h1234;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R7", "in_ready after palette-only load", int'(in_ready), 0);
      end
      chk(got_q.size() == 0, "R7", "pixels after palette-only load", got_q.size(), 0);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_frame(input int nw, input int seed, input string req);
    int b;
    b = bpp_of(cur_code);
    got_q.delete();
    exp_q.delete();
    for (int k = 0; k < nw; k++) begin
      logic [15:0] w;
      w = 16'(k * 16'h3B5D + seed * 16'h01F1 + 16'h0C4A);
      if (b == 16) exp_q.push_back(w[11:0]);
      else for (int j = 0; j < 16 / b; j++) exp_q.push_back(exp_tab[(w >> (j * b)) & ((1 << b) - 1)]);
      send(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int t = 0; t < 300 && got_q.size() < exp_q.size(); t++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    chk(got_q.size() == exp_q.size(), req, "pixel count", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, $sformatf("pixel %0d", i), int'(got_q[i]), int'(exp_q[i]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
    chk(pix_valid == 1'b0, "R1", "pix_valid in reset", int'(pix_valid), 0);
    chk(pal_done == 1'b0, "R1", "pal_done in reset", int'(pal_done), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_before_palette();
    start(2'b10);
    send_frame(4, 1, "R11 R1");
    stop();
  endtask

  task automatic t_palette_only_8bpp();
    start(2'b01);
    load_pal(4'd3, 2, 1'b1);
    stop();
    start(2'b10);
    send_frame(6, 3, "R4 R9 8bpp");
    stop();
  endtask

  task automatic t_pal_then_frame(input logic [3:0] c, input int seed, input string req);
    start(2'b00);
    load_pal(c, seed, 1'b0);
    send_frame(5, seed + 1, req);
    stop();
  endtask

  task automatic t_high_code();
    start(2'b01);
    load_pal(4'd9, 7, 1'b1);
    stop();
    start(2'b11);
    send_frame(4, 8, "R3 R10 code9");
    stop();
  endtask

  task automatic t_backpressure();
    start(2'b00);
    bp_en = 1'b1;
    load_pal(4'd3, 9, 1'b0);
    send_frame(8, 10, "R12 R5 stall");
    bp_en = 1'b0;
    stop();
  endtask

  task automatic t_retain();
    start(2'b10);
    send_frame(3, 11, "R12 retain");
    stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_tab[i] = '0;
    t_reset();
    t_before_palette();
    t_palette_only_8bpp();
    t_pal_then_frame(4'd2, 20, "R5 R8 R9 4bpp");
    t_pal_then_frame(4'd1, 30, "R5 R8 R9 2bpp");
    t_pal_then_frame(4'd0, 40, "R3 R9 1bpp");
    t_pal_then_frame(4'd4, 50, "R10 R5 passthrough");
    t_high_code();
    t_backpressure();
    t_retain();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule